// File: doc/BRIEF.md
# Output Short Protection Retry Latch

This block watches a digital short-detect flag that the power stage raises while an output is shorted. The flag first passes through a synchronizer, then through a run-length filter. Once it qualifies as a fault, the block forces the outputs off by asserting `out_kill`. It holds them off for a fixed number of clock cycles and then releases them once as a retry.

During the retry the filter starts again from zero. If the short qualifies again within a bounded observation window, the block latches into standby: `out_kill` and `fault_latched` both stay high. If the window passes clean, the block returns to normal operation and the single retry is available again.

The latched standby survives any activity on the short input. It is cleared only by taking `chip_en` low, which returns the block to its idle state on the next clock edge. The off time is a parameter in clock cycles. Its default of 32000 cycles equals 256 µs at 125 MHz.

Top module: `short_guard`

## Requirements
- R1: The short input is sampled through `SYNC_STAGES` flops and then counted as a fault only when it has been high on `FILT_LEN` consecutive sampled edges. A shorter pulse, for example 3 cycles with `FILT_LEN`=4, leaves `out_kill` low.
- R2: In normal operation a qualified fault asserts `out_kill` on the next clock edge. The total latency is `SYNC_STAGES`+`FILT_LEN`+1 rising edges, counted from the first edge that samples the short input high.
- R3: Once asserted by a first fault, `out_kill` stays high for exactly `OFF_CYCLES` clock cycles whatever the short input does, and then drops for the retry.
- R4: During the retry the filter restarts from zero. A fault that qualifies within `WIN_CYCLES` cycles of the retry start sets `out_kill` and `fault_latched` high together.
- R5: If `WIN_CYCLES` cycles of retry pass without a qualified fault, the block returns to normal with the retry re-armed. The next fault then gives another off interval with `fault_latched` low.
- R6: While latched and with `chip_en` high, `out_kill` and `fault_latched` stay high regardless of the short input.
- R7: A clock edge with `chip_en` low returns the block to normal with both outputs low and the filter emptied. This has priority over every other transition in the same cycle, including latching.
- R8: After `rst_n` is asserted low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable; low clears every state including the latch |
| short_raw | input | 1 | Asynchronous short-detect flag from the power stage |
| out_kill | output | 1 | High forces the power outputs off |
| fault_latched | output | 1 | High while the block is latched in standby |

## Verification
The interesting collision is `chip_en` going low on the very edge where a second fault completes its filter run during the retry window. In that cycle a latch and a clear compete. The bench provokes it by holding the short through the retry and dropping enable one cycle before the run length is reached. It also lets random enable drops land on arbitrary cycles. The result is judged by both outputs being low at the following falling edge, and by a later fault producing only an off interval with no latch.

// File: rtl/sg_pkg.sv
package sg_pkg;

   typedef enum logic [1:0] {
      SG_NORMAL   = 2'd0,
      SG_OFF_WAIT = 2'd1,
      SG_RETRY    = 2'd2,
      SG_LATCHED  = 2'd3
   } sg_state_t;

   function automatic logic sg_kills(input sg_state_t s);
      return (s == SG_OFF_WAIT) || (s == SG_LATCHED);
   endfunction

   function automatic int sg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   initial begin
      assert (STAGES >= 2) else $error("sg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stage_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= 1'b0;
            else        stage_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= 1'b0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sg_filter.sv
module sg_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic det
);
   initial begin
      assert (LEN >= 1) else $error("sg_filter: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_single
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   hit_q <= 1'b0;
         else if (clr) hit_q <= 1'b0;
         else          hit_q <= din;
      end
      assign det = hit_q;
   end else begin : g_count
      localparam int CW = $clog2(LEN + 1);
      localparam logic [CW-1:0] TOP = CW'(LEN);
      logic [CW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          run_q <= '0;
         else if (clr || !din) run_q <= '0;
         else if (run_q != TOP) run_q <= run_q + 1'b1;
      end
      assign det = (run_q == TOP);
   end

   // R1: a qualified detection needs the input high on the previous edge
   p_det_needs_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
      det |-> $past(din));

   // R7: a clear leaves no detection behind
   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !det);
endmodule

// File: rtl/sg_timer.sv
module sg_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (load)               cnt_q <= load_val;
      else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   p_dec_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sg_retry_fsm.sv
module sg_retry_fsm
   import sg_pkg::*;
#(
   parameter int OFF_CYCLES = 32000,
   parameter int WIN_CYCLES = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      chip_en,
   input  logic      fault,
   output sg_state_t state
);
   localparam int TW = $clog2(sg_max(OFF_CYCLES, WIN_CYCLES) + 1);
   localparam logic [TW-1:0] OFF_LOAD = TW'(OFF_CYCLES - 1);
   localparam logic [TW-1:0] WIN_LOAD = TW'(WIN_CYCLES - 1);

   initial begin
      assert (OFF_CYCLES >= 2) else $error("sg_retry_fsm: OFF_CYCLES too small");
      assert (WIN_CYCLES >= 2) else $error("sg_retry_fsm: WIN_CYCLES too small");
   end

   sg_state_t     state_q, state_d;
   logic          t_load, t_dec, t_zero;
   logic [TW-1:0] t_val;

   sg_timer #(.W(TW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .dec      (t_dec),
      .zero     (t_zero)
   );

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = OFF_LOAD;
      t_dec   = 1'b0;
      if (!chip_en) begin
         state_d = SG_NORMAL;
      end else begin
         unique case (state_q)
            SG_NORMAL: begin
               if (fault) begin
                  state_d = SG_OFF_WAIT;
                  t_load  = 1'b1;
                  t_val   = OFF_LOAD;
               end
            end
            SG_OFF_WAIT: begin
               if (t_zero) begin
                  state_d = SG_RETRY;
                  t_load  = 1'b1;
                  t_val   = WIN_LOAD;
               end else begin
                  t_dec = 1'b1;
               end
            end
            SG_RETRY: begin
               if (fault)       state_d = SG_LATCHED;
               else if (t_zero) state_d = SG_NORMAL;
               else             t_dec   = 1'b1;
            end
            SG_LATCHED: state_d = SG_LATCHED;
            default:    state_d = SG_NORMAL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SG_NORMAL;
      else        state_q <= state_d;
   end

   assign state = state_q;

   p_fault_kills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SG_NORMAL && fault && chip_en) |=> (state_q == SG_OFF_WAIT));

   p_off_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SG_OFF_WAIT && !t_zero && chip_en) |=> (state_q == SG_OFF_WAIT));

   p_retry_after_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SG_RETRY) |-> ($past(state_q) == SG_OFF_WAIT || $past(state_q) == SG_RETRY));

   p_latch_from_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SG_LATCHED) |-> ($past(state_q) == SG_RETRY || $past(state_q) == SG_LATCHED));

   p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SG_LATCHED && chip_en) |=> (state_q == SG_LATCHED));

   p_enable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> (state_q == SG_NORMAL));
endmodule

// File: rtl/short_guard.sv
module short_guard
   import sg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter int OFF_CYCLES  = 32000,
   parameter int WIN_CYCLES  = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_en,
   input  logic short_raw,
   output logic out_kill,
   output logic fault_latched
);
   initial begin
      assert (WIN_CYCLES >= FILT_LEN + 1)
         else $error("short_guard: retry window shorter than filter run");
   end

   logic      short_s, fault_det, filt_clr;
   sg_state_t st;

   sg_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (short_raw),
      .dout  (short_s)
   );

   assign filt_clr = !chip_en || sg_kills(st);

   sg_filter #(.LEN(FILT_LEN)) i_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (filt_clr),
      .din   (short_s),
      .det   (fault_det)
   );

   sg_retry_fsm #(.OFF_CYCLES(OFF_CYCLES), .WIN_CYCLES(WIN_CYCLES)) i_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .chip_en (chip_en),
      .fault   (fault_det),
      .state   (st)
   );

   assign out_kill      = sg_kills(st);
   assign fault_latched = (st == SG_LATCHED);

   p_latched_kills_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> out_kill);

   p_enable_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> (!out_kill && !fault_latched));
endmodule

// File: tb/test_short_guard.sv
module test_short_guard;
   localparam int SYNC = 2;
   localparam int FILT = 4;
   localparam int OFFC = 40;
   localparam int WINC = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_en = 1'b1;
   logic short_raw = 1'b0;
   logic out_kill, fault_latched;

   int checks = 0;
   int failures = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   short_guard #(.SYNC_STAGES(SYNC), .FILT_LEN(FILT), .OFF_CYCLES(OFFC), .WIN_CYCLES(WINC))
   i_short_guard (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .short_raw(short_raw),
      .out_kill(out_kill), .fault_latched(fault_latched)
   );

   // reference model from the requirements: 0 normal, 1 off, 2 retry, 3 latched
   int  m_st = 0;
   int  m_run = 0;
   int  m_left = 0;
   bit  m_pipe [SYNC];

   function automatic bit exp_kill(int s);
      return (s == 1) || (s == 3);
   endfunction

   function automatic bit exp_latch(int s);
      return s == 3;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_run = 0; m_left = 0;
         for (int i = 0; i < SYNC; i++) m_pipe[i] = 1'b0;
      end else begin
         bit qual, synced;
         int nst, nrun, nleft;
         qual = (m_run >= FILT);
         synced = m_pipe[SYNC-1];
         nst = m_st; nleft = m_left;
         if (!chip_en || exp_kill(m_st)) nrun = 0;
         else if (synced) nrun = (m_run < FILT) ? m_run + 1 : FILT;
         else nrun = 0;
         if (!chip_en) nst = 0;
         else case (m_st)
            0: if (qual) begin nst = 1; nleft = OFFC; end
            1: begin nleft = m_left - 1; if (nleft == 0) begin nst = 2; nleft = WINC; end end
            2: if (qual) nst = 3;
               else begin nleft = m_left - 1; if (nleft == 0) nst = 0; end
            default: nst = 3;
         endcase
         for (int i = SYNC - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
         m_pipe[0] = short_raw;
         m_st = nst; m_run = nrun; m_left = nleft;
      end
   end

   task automatic chk(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (model_on && rst_n) begin
         string tag;
         case (m_st)
            1: tag = "R3 model";
            2: tag = "R4 model";
            3: tag = "R6 model";
            default: tag = "R2 model";
         endcase
         if (!chip_en) tag = "R7 model";
         chk({tag, " kill"}, out_kill, exp_kill(m_st));
         chk({tag, " latch"}, fault_latched, exp_latch(m_st));
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      chk("R8 reset kill", out_kill, 1'b0);
      chk("R8 reset latch", fault_latched, 1'b0);

      // R1: 3-cycle pulse must not qualify
      short_raw = 1'b1; wait_n(3); short_raw = 1'b0; wait_n(20);
      chk("R1 short pulse ignored", out_kill, 1'b0);

      // R2: latency
      short_raw = 1'b1;
      wait_n(6); chk("R2 not yet killed", out_kill, 1'b0);
      wait_n(1); chk("R2 kill asserted", out_kill, 1'b1);
      // R3: off time with short held
      wait_n(OFFC - 1); chk("R3 still off", out_kill, 1'b1);
      wait_n(1); chk("R3 retry releases", out_kill, 1'b0);
      // R4: short persists during retry
      wait_n(FILT); chk("R4 not latched yet", fault_latched, 1'b0);
      wait_n(1); chk("R4 latched", fault_latched, 1'b1);
      chk("R4 kill with latch", out_kill, 1'b1);
      // R6: latch ignores short input
      for (int i = 0; i < 100; i++) begin short_raw = i[2]; wait_n(1); end
      chk("R6 latch held", fault_latched, 1'b1);
      chk("R6 kill held", out_kill, 1'b1);
      // R7: enable low clears
      short_raw = 1'b0; chip_en = 1'b0; wait_n(1);
      chk("R7 clear kill", out_kill, 1'b0);
      chk("R7 clear latch", fault_latched, 1'b0);
      chip_en = 1'b1; wait_n(5);

      // R1: exactly FILT cycles qualifies; R5: clean retry re-arms
      short_raw = 1'b1; wait_n(FILT); short_raw = 1'b0; wait_n(3);
      chk("R1 full run trips", out_kill, 1'b1);
      wait_n(OFFC + WINC + 5);
      chk("R5 back to normal kill", out_kill, 1'b0);
      chk("R5 back to normal latch", fault_latched, 1'b0);
      short_raw = 1'b1; wait_n(7);
      chk("R5 second trip off", out_kill, 1'b1);
      chk("R5 second trip no latch", fault_latched, 1'b0);
      // R7 priority: enable drops on the edge the retry fault would latch
      wait_n(OFFC); wait_n(FILT);
      chip_en = 1'b0; wait_n(1);
      chk("R7 priority kill", out_kill, 1'b0);
      chk("R7 priority latch", fault_latched, 1'b0);
      chip_en = 1'b1; short_raw = 1'b0; wait_n(10);
      chk("R7 stays clear", fault_latched, 1'b0);

      // random phase against the model
      model_on = 1'b1;
      begin
         int run_left = 0;
         int en_left = 0;
         for (int c = 0; c < 6000; c++) begin
            if (run_left == 0) begin
               short_raw = ($urandom % 3 == 0);
               run_left = short_raw ? 1 + $urandom % 14 : 1 + $urandom % 50;
            end
            run_left--;
            if (en_left > 0) begin
               en_left--;
               chip_en = (en_left == 0);
            end else if ($urandom % 250 == 0) begin
               chip_en = 1'b0;
               en_left = 1 + $urandom % 3;
            end
            wait_n(1);
         end
      end
      model_on = 1'b0;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule